// File: doc/BRIEF.md
# Fractional DSP Arithmetic Unit

This block is the arithmetic stage of a small audio-effects signal processor. Each valid cycle it takes a 4-bit opcode and three signed operands, A, X and Y, and one clock later presents a result R together with a condition-code word that describes R. The operations are:

- multiply-accumulate on Q1.31 fractions, with a negated-product form;
- multiply-accumulate on integers;
- a three-way add;
- a mask-and-toggle bit operation;
- three signed compare-and-select operations;
- linear interpolation between A and Y with X as the weight.

A hidden 64-bit accumulator collects fractional products through one dedicated opcode. That opcode passes A through to R unchanged.

All arithmetic opcodes share one signed multiplier. The second multiplier operand is chosen per opcode: Y, minus Y, or Y minus A. Sums are formed wide enough that no intermediate value can overflow. The selected sum is then either clamped to the signed result range or truncated. The accumulator value is brought out on a port so that the rest of the processor can observe it.

Top module: `fdsp_alu`

## Requirements
- R1: The fractional multiply-accumulate opcodes compute R = A + floor(P / 2^31), where P is the exact signed product.
  - Opcodes 0x0 and 0x2 use P = X*Y.
  - Opcodes 0x1 and 0x3 use P = (-X)*Y.
  - Opcodes 0x0 and 0x1 clamp to 0x7FFFFFFF or 0x80000000 when the exact value falls outside the 32-bit signed range.
  - Opcodes 0x2 and 0x3 keep the low 32 bits instead.
- R2: Opcode 0x4 computes the exact integer value A + X*Y and clamps it as in R1. Opcode 0x5 keeps bits 30..0 of A + X*Y and copies bit 30 into bit 31.
- R3: Opcode 0x6 computes A + X + Y and clamps it as in R1.
- R4: Opcode 0x7 gives R = A, and adds floor(X*Y / 2^31), sign-extended to 64 bits, into the accumulator. The addition wraps at 64 bits. The accumulator changes only in a cycle where valid_i is high and op_i is 0x7.
- R5: Opcode 0x8 gives R = (A AND X) XOR Y.
- R6: The compare-and-select opcodes all compare A with Y as signed values:
  - Opcode 0x9 gives X if A >= Y, otherwise NOT X.
  - Opcode 0xA gives X if A >= Y, otherwise Y.
  - Opcode 0xB gives X if A < Y, otherwise Y.
- R7: Opcode 0xE computes A + floor(X*(Y-A) / 2^31) exactly and clamps it as in R1.
- R8: Opcodes 0xC, 0xD and 0xF give R = A.
- R9: The condition word cc_o is derived from R. Bits 5 to 7 are always 0.
  - Bit 0 is R[31] XOR R[30].
  - Bit 1 is set for opcodes 0x9 to 0xB when A < Y (signed), and is 0 for every other opcode.
  - Bit 2 is R[31].
  - Bit 3 is set when R is zero.
  - Bit 4 is set when a clamping opcode (0x0, 0x1, 0x4, 0x6, 0xE) clamped its result.
  - Bit 8 is set when R is nonzero.
- R10: r_o and cc_o update on the clock edge that samples valid_i high. They hold their value when valid_i is low. vld_o is valid_i delayed by one clock.
- R11: Synchronous active-high reset clears r_o, cc_o, vld_o and acc_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| a_i | input | W (32) | Operand A, signed |
| x_i | input | W (32) | Operand X, signed |
| y_i | input | W (32) | Operand Y, signed |
| r_o | output | W (32) | Registered result |
| cc_o | output | 9 | Registered condition word |
| vld_o | output | 1 | Result valid, one clock after valid_i |
| acc_o | output | ACC_W (64) | Accumulator value |

## Verification
The bench builds the unit with its defaults: a 32-bit data path and a 64-bit accumulator. At these widths the products that matter are all reachable:
- the full-scale negative times negative product, whose shifted value exceeds the positive limit;
- the interpolation product near 2^63, where Y-A needs 33 bits;
- the sign-extended negative accumulator sums.

Because the widths are the defaults, every expected value in the vector table is an exact hand-computed 32-bit constant. The table also places the wrap-versus-clamp opcode pairs on the same operands, so that any difference between them shows up directly.

// File: rtl/fdsp_pkg.sv
package fdsp_pkg;
  typedef enum logic [3:0] {
    OP_FMAC   = 4'h0,
    OP_FMSU   = 4'h1,
    OP_FMACW  = 4'h2,
    OP_FMSUW  = 4'h3,
    OP_IMAC   = 4'h4,
    OP_IMACW  = 4'h5,
    OP_SUM3   = 4'h6,
    OP_ACCUM  = 4'h7,
    OP_MASKX  = 4'h8,
    OP_SELNOT = 4'h9,
    OP_SELGE  = 4'hA,
    OP_SELLT  = 4'hB,
    OP_PASSC  = 4'hC,
    OP_PASSD  = 4'hD,
    OP_LERP   = 4'hE,
    OP_PASSF  = 4'hF
  } fdsp_op_e;

  localparam int CC_W     = 9;
  localparam int FLG_NORM = 0;
  localparam int FLG_BRW  = 1;
  localparam int FLG_NEG  = 2;
  localparam int FLG_ZERO = 3;
  localparam int FLG_SAT  = 4;
  localparam int FLG_NZ   = 8;
endpackage

// File: rtl/fdsp_mul.sv
// Shared signed multiplier; second operand chosen per opcode.
module fdsp_mul
  import fdsp_pkg::*;
#(
  parameter int W = 32,
  localparam int PW = 2*W+1
) (
  input  fdsp_op_e               op,
  input  logic signed [W-1:0]    a,
  input  logic signed [W-1:0]    x,
  input  logic signed [W-1:0]    y,
  output logic signed [PW-1:0]   prod,
  output logic signed [PW-1:0]   frac
);
  logic signed [W:0]    y1, a1, mb;
  logic signed [PW-1:0] xw, bw;

  assign y1 = {y[W-1], y};
  assign a1 = {a[W-1], a};

  always_comb begin
    case (op)
      OP_FMSU, OP_FMSUW: mb = -y1;
      OP_LERP:           mb = y1 - a1;
      default:           mb = y1;
    endcase
  end

  assign xw   = {{(W+1){x[W-1]}}, x};
  assign bw   = {{W{mb[W]}}, mb};
  assign prod = xw * bw;
  assign frac = prod >>> (W-1);
endmodule

// File: rtl/fdsp_core.sv
// Wide sums, clamp/wrap selection and the logic/select opcodes.
module fdsp_core
  import fdsp_pkg::*;
#(
  parameter int W = 32,
  localparam int PW = 2*W+1
) (
  input  fdsp_op_e               op,
  input  logic signed [W-1:0]    a,
  input  logic signed [W-1:0]    x,
  input  logic signed [W-1:0]    y,
  input  logic signed [PW-1:0]   prod,
  input  logic signed [PW-1:0]   frac,
  output logic [W-1:0]           r,
  output logic                   sat,
  output logic                   brw
);
  localparam int SW = 2*W+2;
  localparam logic signed [SW-1:0] SMAX = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = ~SMAX;
  localparam logic [W-1:0] RMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] RMIN = {1'b1, {(W-1){1'b0}}};

  logic signed [SW-1:0] ae, xe, ye, fe, pe;
  logic signed [SW-1:0] s_frac, s_int, s_sum3, s_sel;
  logic over, under, clip, ge;
  logic [W-1:0] sat_val;

  assign ae = {{(SW-W){a[W-1]}}, a};
  assign xe = {{(SW-W){x[W-1]}}, x};
  assign ye = {{(SW-W){y[W-1]}}, y};
  assign fe = {frac[PW-1], frac};
  assign pe = {prod[PW-1], prod};

  assign s_frac = ae + fe;
  assign s_int  = ae + pe;
  assign s_sum3 = ae + xe + ye;

  always_comb begin
    case (op)
      OP_IMAC, OP_IMACW: s_sel = s_int;
      OP_SUM3:           s_sel = s_sum3;
      default:           s_sel = s_frac;
    endcase
  end

  assign over    = s_sel > SMAX;
  assign under   = s_sel < SMIN;
  assign clip    = over | under;
  assign sat_val = over ? RMAX : RMIN;
  assign ge      = a >= y;

  always_comb begin
    r   = a;
    sat = 1'b0;
    brw = 1'b0;
    case (op)
      OP_FMAC, OP_FMSU, OP_IMAC, OP_SUM3, OP_LERP: begin
        r   = clip ? sat_val : s_sel[W-1:0];
        sat = clip;
      end
      OP_FMACW, OP_FMSUW: r = s_sel[W-1:0];
      OP_IMACW:           r = {s_sel[W-2], s_sel[W-2:0]};
      OP_MASKX:           r = (a & x) ^ y;
      OP_SELNOT: begin
        r   = ge ? x : ~x;
        brw = ~ge;
      end
      OP_SELGE: begin
        r   = ge ? x : y;
        brw = ~ge;
      end
      OP_SELLT: begin
        r   = ge ? y : x;
        brw = ~ge;
      end
      default: r = a;
    endcase
  end
endmodule

// File: rtl/fdsp_flags.sv
// Condition word built from the next result.
module fdsp_flags
  import fdsp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     r,
  input  logic             sat,
  input  logic             brw,
  output logic [CC_W-1:0]  cc
);
  always_comb begin
    cc           = '0;
    cc[FLG_NORM] = r[W-1] ^ r[W-2];
    cc[FLG_BRW]  = brw;
    cc[FLG_NEG]  = r[W-1];
    cc[FLG_ZERO] = (r == '0);
    cc[FLG_SAT]  = sat;
    cc[FLG_NZ]   = (r != '0);
  end
endmodule

// File: rtl/fdsp_acc.sv
// Hidden wide accumulator, fed with the shifted fractional product.
module fdsp_acc #(
  parameter int ACC_W = 64,
  parameter int FW    = 34
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [FW-1:0]   add,
  output logic [ACC_W-1:0]       acc
);
  logic [ACC_W-1:0] add_ext;

  generate
    if (ACC_W > FW) begin : g_ext
      assign add_ext = {{(ACC_W-FW){add[FW-1]}}, add};
    end else begin : g_trunc
      assign add_ext = add[ACC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= acc + add_ext;
  end
endmodule

// File: rtl/fdsp_alu.sv
module fdsp_alu
  import fdsp_pkg::*;
#(
  parameter int W     = 32,
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     x_i,
  input  logic [W-1:0]     y_i,
  output logic [W-1:0]     r_o,
  output logic [CC_W-1:0]  cc_o,
  output logic             vld_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam int PW = 2*W+1;
  localparam int FW = W+2;

  fdsp_op_e           op;
  logic signed [PW-1:0] prod, frac;
  logic [W-1:0]       r_n;
  logic               sat_n, brw_n;
  logic [CC_W-1:0]    cc_n;

  assign op = fdsp_op_e'(op_i);

  fdsp_mul #(.W(W)) u_mul (
    .op(op), .a(a_i), .x(x_i), .y(y_i), .prod(prod), .frac(frac)
  );

  fdsp_core #(.W(W)) u_core (
    .op(op), .a(a_i), .x(x_i), .y(y_i), .prod(prod), .frac(frac),
    .r(r_n), .sat(sat_n), .brw(brw_n)
  );

  fdsp_flags #(.W(W)) u_flags (
    .r(r_n), .sat(sat_n), .brw(brw_n), .cc(cc_n)
  );

  fdsp_acc #(.ACC_W(ACC_W), .FW(FW)) u_acc (
    .clk(clk), .rst(rst), .en(valid_i && (op == OP_ACCUM)),
    .add(frac[FW-1:0]), .acc(acc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      r_o   <= '0;
      cc_o  <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        r_o  <= r_n;
        cc_o <= cc_n;
      end
    end
  end
endmodule

// File: rtl/fdsp_alu_chk.sv
module fdsp_alu_chk #(
  parameter int W     = 32,
  parameter int ACC_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [W-1:0]     a_i,
  input logic [W-1:0]     x_i,
  input logic [W-1:0]     y_i,
  input logic [W-1:0]     r_o,
  input logic             cc_sat,
  input logic             vld_o,
  input logic [ACC_W-1:0] acc_o
);
  localparam logic [W-1:0] RMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] RMIN = {1'b1, {(W-1){1'b0}}};

  // R10
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> vld_o);

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(r_o));

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid_i && op_i == 4'h7) |=> $stable(acc_o));

  // R4
  accum_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 4'h7) |=> r_o == $past(a_i));

  // R8
  pass_ops_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == 4'hC || op_i == 4'hD || op_i == 4'hF)) |=> r_o == $past(a_i));

  // R6
  select_src_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == 4'hA || op_i == 4'hB)) |=> (r_o == $past(x_i) || r_o == $past(y_i)));

  // R9
  sat_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_o && cc_sat) |-> (r_o == RMAX || r_o == RMIN));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && !vld_o && r_o == '0));
endmodule

bind fdsp_alu fdsp_alu_chk #(.W(W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .a_i(a_i),
  .x_i(x_i), .y_i(y_i), .r_o(r_o), .cc_sat(cc_o[4]), .vld_o(vld_o),
  .acc_o(acc_o)
);

// File: tb/tb_fdsp_alu.sv
`timescale 1ns/1ps
module tb_fdsp_alu;
  localparam int W = 32;
  localparam int ACC_W = 64;
  localparam int NV = 30;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a, x, y, r;
    logic [8:0]  cc;
    logic [3:0]  req;
  } vec_t;

  // expected values per requirement; tag in comments
  localparam vec_t VEC [NV] = '{
    '{4'h0, 32'h00000010, 32'h40000000, 32'h40000000, 32'h20000010, 9'h100, 4'd1}, // R1
    '{4'h0, 32'h7FFFFFF0, 32'h40000000, 32'h40000000, 32'h7FFFFFFF, 9'h111, 4'd1}, // R1 clamp
    '{4'h0, 32'h00000000, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, 9'h111, 4'd1}, // R1 -1*-1
    '{4'h0, 32'h00000000, 32'h00000001, 32'h00000001, 32'h00000000, 9'h008, 4'd1}, // R1 floor
    '{4'h1, 32'h00000000, 32'h40000000, 32'h40000000, 32'hE0000000, 9'h104, 4'd1}, // R1
    '{4'h1, 32'h00000000, 32'h00000001, 32'h00000001, 32'hFFFFFFFF, 9'h104, 4'd1}, // R1 floor
    '{4'h1, 32'h80000010, 32'h40000000, 32'h40000000, 32'h80000000, 9'h115, 4'd1}, // R1 clamp
    '{4'h2, 32'h7FFFFFF0, 32'h40000000, 32'h40000000, 32'h9FFFFFF0, 9'h105, 4'd1}, // R1 wrap
    '{4'h3, 32'h80000010, 32'h40000000, 32'h40000000, 32'h60000010, 9'h101, 4'd1}, // R1 wrap
    '{4'h4, 32'h00000005, 32'h00000003, 32'hFFFFFFFC, 32'hFFFFFFF9, 9'h104, 4'd2}, // R2
    '{4'h4, 32'h00000000, 32'h00010000, 32'h00010000, 32'h7FFFFFFF, 9'h111, 4'd2}, // R2 clamp
    '{4'h5, 32'h00000000, 32'h00008000, 32'h00008000, 32'hC0000000, 9'h104, 4'd2}, // R2 wrap31
    '{4'h5, 32'h00000001, 32'h00000002, 32'h00000003, 32'h00000007, 9'h100, 4'd2}, // R2
    '{4'h6, 32'h00000001, 32'h00000002, 32'h00000003, 32'h00000006, 9'h100, 4'd3}, // R3
    '{4'h6, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 9'h111, 4'd3}, // R3
    '{4'h6, 32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000, 9'h115, 4'd3}, // R3
    '{4'h7, 32'h00000055, 32'h40000000, 32'h40000000, 32'h00000055, 9'h100, 4'd4}, // R4
    '{4'h8, 32'hFF00FF00, 32'h0F0F0F0F, 32'h12345678, 32'h1D345978, 9'h100, 4'd5}, // R5
    '{4'h9, 32'h00000005, 32'h00001234, 32'h00000003, 32'h00001234, 9'h100, 4'd6}, // R6
    '{4'h9, 32'hFFFFFFFF, 32'h00001234, 32'h00000003, 32'hFFFFEDCB, 9'h106, 4'd6}, // R6 signed
    '{4'hA, 32'h00000003, 32'h00000007, 32'h00000003, 32'h00000007, 9'h100, 4'd6}, // R6 equal
    '{4'hA, 32'h80000000, 32'h00000007, 32'h00000000, 32'h00000000, 9'h00A, 4'd6}, // R6
    '{4'hB, 32'h80000000, 32'h00000007, 32'h00000000, 32'h00000007, 9'h102, 4'd6}, // R6
    '{4'hB, 32'h00000003, 32'h00000007, 32'h00000003, 32'h00000003, 9'h100, 4'd6}, // R6 equal
    '{4'hE, 32'h00000000, 32'h40000000, 32'h40000000, 32'h20000000, 9'h100, 4'd7}, // R7
    '{4'hE, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, 32'h80000000, 9'h115, 4'd7}, // R7 wide
    '{4'hE, 32'h40000000, 32'h40000000, 32'h00000000, 32'h20000000, 9'h100, 4'd7}, // R7
    '{4'hC, 32'hDEADBEEF, 32'h00000000, 32'h00000000, 32'hDEADBEEF, 9'h104, 4'd8}, // R8
    '{4'hD, 32'h40000000, 32'h00000005, 32'h00000005, 32'h40000000, 9'h101, 4'd8}, // R8
    '{4'hF, 32'h00000000, 32'h00000009, 32'h00000009, 32'h00000000, 9'h008, 4'd8}  // R8
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [W-1:0] a_i = '0, x_i = '0, y_i = '0;
  logic [W-1:0] r_o;
  logic [8:0] cc_o;
  logic vld_o;
  logic [ACC_W-1:0] acc_o;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  fdsp_alu #(.W(W), .ACC_W(ACC_W)) dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .a_i(a_i),
    .x_i(x_i), .y_i(y_i), .r_o(r_o), .cc_o(cc_o), .vld_o(vld_o), .acc_o(acc_o)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    valid_i = v; op_i = op; a_i = a; x_i = x; y_i = y;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 r_o after reset", 64'(r_o), 64'h0);
    chk("R11 cc_o after reset", 64'(cc_o), 64'h0);
    chk("R11 vld_o after reset", 64'(vld_o), 64'h0);
    chk("R11 acc_o after reset", acc_o, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].op, VEC[i].a, VEC[i].x, VEC[i].y);
      chk($sformatf("R%0d vec %0d result", VEC[i].req, i), 64'(r_o), 64'(VEC[i].r));
      chk($sformatf("R9 vec %0d flags", i), 64'(cc_o), 64'(VEC[i].cc));
    end

    // R10 valid follows one clock later
    chk("R10 vld_o after valid", 64'(vld_o), 64'h1);
    // R4 only the single opcode-7 vector touched the accumulator
    chk("R4 acc after table", acc_o, 64'h0000_0000_2000_0000);

    drive(1'b1, 4'h7, 32'h00000011, 32'h80000000, 32'h80000000);
    chk("R4 acc +2^31", acc_o, 64'h0000_0000_A000_0000);
    chk("R4 result is A", 64'(r_o), 64'h11);

    drive(1'b1, 4'h7, 32'h00000077, 32'h80000000, 32'h40000000);
    chk("R4 acc negative add", acc_o, 64'h0000_0000_6000_0000);

    // R10 / R4: no strobe, nothing changes
    drive(1'b0, 4'h7, 32'h00000099, 32'h40000000, 32'h40000000);
    chk("R4 acc without strobe", acc_o, 64'h0000_0000_6000_0000);
    chk("R10 r_o held", 64'(r_o), 64'h77);
    chk("R10 vld_o low", 64'(vld_o), 64'h0);

    drive(1'b1, 4'h7, 32'h00000000, 32'h80000000, 32'h7FFFFFFF);
    chk("R4 acc sign extension", acc_o, 64'hFFFF_FFFF_E000_0001);

    drive(1'b1, 4'h6, 32'h00000001, 32'h00000001, 32'h00000001);
    chk("R4 acc unaffected by other op", acc_o, 64'hFFFF_FFFF_E000_0001);

    // R11 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 acc cleared", acc_o, 64'h0);
    chk("R11 r_o cleared", 64'(r_o), 64'h0);
    chk("R11 cc_o cleared", 64'(cc_o), 64'h0);
    chk("R11 vld_o cleared", 64'(vld_o), 64'h0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule